// File: doc/BRIEF.md
# Flash Status Register and Write Guard

This block keeps the 8-bit status register of a serial flash memory model and decides which write operations may go ahead. The command decoder in front of it hands over one decoded command event per cycle: write-enable, write-disable, status-write arming, status write with its data byte, write start, and write completion. The array controller supplies the live busy and auto-increment-programming flags. The block also watches the level of the active-low write-protect pin.

The outputs are the assembled status byte, which the serial side shifts out, and the write-enable latch on its own pin. Two permission signals follow the current state. One says whether a program or erase on the presented target address and span may proceed. The other says whether a whole-chip erase may proceed.

Command events are single-cycle pulses qualified by `cmd_valid`. There is no back-pressure: the block takes an event in every cycle it is offered. The permission outputs are combinational from the registered state and the target inputs, so the decoder can present an address and read the answer in the same cycle.

Top module: `flash_status_guard`

## Requirements
- R1: After reset the status byte reads 0x1C (protection level bits 4:2 all 1, every other bit 0), `wel` is 0, and both permission outputs are 0.
- R2: The status byte is laid out as follows:
  - bit 0 mirrors `busy_in`;
  - bit 1 is the write-enable latch;
  - bits 4:2 hold the protection level;
  - bit 5 always reads 0;
  - bit 6 mirrors `aai_in`;
  - bit 7 is the lock bit.
- R3: The `cmd_code` values are: 0 other, 1 write-enable, 2 write-disable, 3 status-write arming, 4 status write, 5 write start, 6 write done.
  - Code 1 sets the write-enable latch.
  - Codes 2 and 6 clear it, and so does an accepted code 4.
  - No other event changes it.
- R4: A status write (code 4) is accepted only if the command event just before it was code 1 or code 3. Any other event in between discards the arming.
- R5: With `wp_n` low and the lock bit at 1, a status write is ignored and the lock bit cannot be cleared. With `wp_n` high, the lock bit has no effect.
- R6: An accepted status write loads `cmd_data[4:2]` into the protection level and `cmd_data[7]` into the lock bit, both in one event. The other status bits are not written.
- R7: The protected region depends on the protection level:
  - level 0 protects nothing;
  - level 1 protects the upper eighth of the array;
  - level 2 protects the upper quarter;
  - level 3 protects the upper half;
  - levels 4 to 7 protect the whole array.
- R8: `wr_permit` is 1 only when the write-enable latch is set and the target range does not overlap the protected region. The target range is `tgt_addr` widened according to `tgt_span`: 0 is one byte, 1 is the aligned 4 KiB sector, 2 or 3 is the aligned 64 KiB block.
- R9: `chip_erase_ok` is 1 only when the write-enable latch is set and the protection level is 0.
- R10: A status write is refused while `busy_in` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Qualifies a command event this cycle |
| cmd_code | input | 3 | Decoded command kind (see R3) |
| cmd_data | input | 8 | Data byte carried by a status write |
| busy_in | input | 1 | Internal write in progress, from the array controller |
| aai_in | input | 1 | Auto-increment programming mode, from the array controller |
| wp_n | input | 1 | Write-protect pin level, active low |
| tgt_addr | input | ADDR_W | Target byte address of a requested write |
| tgt_span | input | 2 | Target range size code (see R8) |
| status_byte | output | 8 | Status register read-out |
| wel | output | 1 | Write-enable latch |
| wr_permit | output | 1 | Program or erase on the target range is allowed |
| chip_erase_ok | output | 1 | Whole-chip erase is allowed |

## Verification
The assertions check, on every cycle:
- the set and clear of the write-enable latch by the commands that own it;
- that a status write leaves the level and lock bits untouched when it is unarmed, locked or issued while busy;
- that the lock bit cannot fall while the pin is low;
- that full protection or a cleared latch withholds both permissions.

Only the bench's scenarios show:
- the exact address boundary of each protected fraction;
- the widening of the target by span;
- the reset value;
- that a single intervening event cancels an arming in a longer command history.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

  typedef enum logic [2:0] {
    CMD_OTHER  = 3'd0,
    CMD_WREN   = 3'd1,
    CMD_WRDI   = 3'd2,
    CMD_ARM    = 3'd3,
    CMD_WRSR   = 3'd4,
    CMD_WSTART = 3'd5,
    CMD_WDONE  = 3'd6
  } sr_cmd_e;

  typedef enum logic [1:0] {
    SPAN_BYTE   = 2'd0,
    SPAN_SECTOR = 2'd1,
    SPAN_BLOCK  = 2'd2,
    SPAN_BLOCK2 = 2'd3
  } span_e;

  // Field positions inside the status byte
  localparam int SR_BUSY  = 0;
  localparam int SR_WEL   = 1;
  localparam int SR_LVL_L = 2;
  localparam int SR_LVL_H = 4;
  localparam int SR_RSV   = 5;
  localparam int SR_AAI   = 6;
  localparam int SR_LOCK  = 7;
  localparam int LVL_W    = SR_LVL_H - SR_LVL_L + 1;

  localparam logic [LVL_W-1:0] LVL_RESET = '1;

endpackage

// File: rtl/sr_arm_tracker.sv
// Remembers whether the most recent command event may arm a status write.
module sr_arm_tracker
  import flash_sr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  output logic       armed
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (cmd_valid) begin
      armed <= (cmd_code == CMD_WREN) || (cmd_code == CMD_ARM);
    end
  end

endmodule

// File: rtl/sr_lock_regs.sv
// Writable status fields: protection level, lock bit, write-enable latch.
module sr_lock_regs
  import flash_sr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_code,
  input  logic [7:0]       cmd_data,
  input  logic             armed,
  input  logic             busy_in,
  input  logic             wp_n,
  output logic [LVL_W-1:0] level,
  output logic             lock,
  output logic             wel
);

  logic is_wrsr;
  logic pin_lock;
  logic wrsr_take;

  assign is_wrsr   = cmd_valid && (cmd_code == CMD_WRSR);
  assign pin_lock  = !wp_n && lock;
  assign wrsr_take = is_wrsr && armed && !busy_in && !pin_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= LVL_RESET;
      lock  <= 1'b0;
    end else if (wrsr_take) begin
      level <= cmd_data[SR_LVL_H:SR_LVL_L];
      lock  <= cmd_data[SR_LOCK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0;
    end else if (cmd_valid) begin
      unique case (cmd_code)
        CMD_WREN:            wel <= 1'b1;
        CMD_WRDI, CMD_WDONE: wel <= 1'b0;
        CMD_WRSR:            if (wrsr_take) wel <= 1'b0;
        default:             wel <= wel;
      endcase
    end
  end

endmodule

// File: rtl/sr_range_guard.sv
// Flags a target range that overlaps the upper-fraction protected region.
module sr_range_guard
  import flash_sr_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int SECTOR_W = 12,
  parameter int BLOCK_W  = 16
) (
  input  logic [LVL_W-1:0]  level,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [1:0]        tgt_span,
  output logic              hit
);

  localparam logic [ADDR_W:0]   FULL     = {1'b1, {ADDR_W{1'b0}}};
  localparam logic [ADDR_W-1:0] SEC_MASK = {{(ADDR_W-SECTOR_W){1'b0}}, {SECTOR_W{1'b1}}};
  localparam logic [ADDR_W-1:0] BLK_MASK = {{(ADDR_W-BLOCK_W){1'b0}}, {BLOCK_W{1'b1}}};
  localparam int NFRAC = 3;

  // Start address of the protected top fraction for levels 1..NFRAC
  logic [ADDR_W:0] frac_start [NFRAC+1];

  assign frac_start[0] = FULL;
  for (genvar g = 1; g <= NFRAC; g++) begin : g_frac
    assign frac_start[g] = FULL - (FULL >> (NFRAC + 1 - g));
  end

  logic [ADDR_W-1:0] span_mask;
  logic [ADDR_W-1:0] end_addr;
  logic [ADDR_W:0]   prot_start;

  always_comb begin
    unique case (tgt_span)
      SPAN_BYTE:   span_mask = '0;
      SPAN_SECTOR: span_mask = SEC_MASK;
      default:     span_mask = BLK_MASK;
    endcase
  end

  assign end_addr = tgt_addr | span_mask;

  always_comb begin
    if (level[LVL_W-1]) begin
      prot_start = '0;
    end else begin
      prot_start = frac_start[level[1:0]];
    end
  end

  assign hit = (level != '0) && ({1'b0, end_addr} >= prot_start);

endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
  import flash_sr_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int SECTOR_W = 12,
  parameter int BLOCK_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_code,
  input  logic [7:0]        cmd_data,
  input  logic              busy_in,
  input  logic              aai_in,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [1:0]        tgt_span,
  output logic [7:0]        status_byte,
  output logic              wel,
  output logic              wr_permit,
  output logic              chip_erase_ok
);

  logic             armed;
  logic [LVL_W-1:0] level;
  logic             lock;
  logic             wel_q;
  logic             prot_hit;

  sr_arm_tracker u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .armed     (armed)
  );

  sr_lock_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_data  (cmd_data),
    .armed     (armed),
    .busy_in   (busy_in),
    .wp_n      (wp_n),
    .level     (level),
    .lock      (lock),
    .wel       (wel_q)
  );

  sr_range_guard #(
    .ADDR_W   (ADDR_W),
    .SECTOR_W (SECTOR_W),
    .BLOCK_W  (BLOCK_W)
  ) u_range (
    .level    (level),
    .tgt_addr (tgt_addr),
    .tgt_span (tgt_span),
    .hit      (prot_hit)
  );

  always_comb begin
    status_byte                   = '0;
    status_byte[SR_BUSY]          = busy_in;
    status_byte[SR_WEL]           = wel_q;
    status_byte[SR_LVL_H:SR_LVL_L] = level;
    status_byte[SR_RSV]           = 1'b0;
    status_byte[SR_AAI]           = aai_in;
    status_byte[SR_LOCK]          = lock;
  end

  assign wel           = wel_q;
  assign wr_permit     = wel_q && !prot_hit;
  assign chip_erase_ok = wel_q && (level == '0);

endmodule

// File: rtl/flash_status_guard_chk.sv
module flash_status_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_code,
  input logic       busy_in,
  input logic       wp_n,
  input logic       st_lock,
  input logic [2:0] st_level,
  input logic       st_wel,
  input logic       wr_permit,
  input logic       chip_erase_ok
);

  logic prev_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_en <= 1'b0;
    end else if (cmd_valid) begin
      prev_en <= (cmd_code == 3'd1) || (cmd_code == 3'd3);
    end
  end

  // R3
  wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd1) |=> st_wel);

  // R3
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_code == 3'd2 || cmd_code == 3'd6)) |=> !st_wel);

  // R4
  unarmed_wrsr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd4 && !prev_en) |=> $stable({st_lock, st_level}));

  // R5
  locked_wrsr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd4 && !wp_n && st_lock) |=> $stable({st_lock, st_level}));

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && st_lock) |=> st_lock);

  // R10
  busy_wrsr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd4 && busy_in) |=> $stable({st_lock, st_level}));

  // R9
  chip_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_ok |-> (st_wel && st_level == 3'd0));

  // R7
  full_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_level[2] |-> (!wr_permit && !chip_erase_ok));

  // R8
  open_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_level == 3'd0 && st_wel) |-> wr_permit);

  // R8
  no_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_wel |-> (!wr_permit && !chip_erase_ok));

endmodule

bind flash_status_guard flash_status_guard_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_code      (cmd_code),
  .busy_in       (busy_in),
  .wp_n          (wp_n),
  .st_lock       (status_byte[7]),
  .st_level      (status_byte[4:2]),
  .st_wel        (status_byte[1]),
  .wr_permit     (wr_permit),
  .chip_erase_ok (chip_erase_ok)
);

// File: tb/sim_flash_status_guard.sv
`timescale 1ns/1ps
module sim_flash_status_guard;

  localparam int ADDR_W = 19;
  localparam int NV     = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [2:0]        cmd_code = 3'd0;
  logic [7:0]        cmd_data = 8'h00;
  logic              busy_in = 1'b0;
  logic              aai_in = 1'b0;
  logic              wp_n = 1'b1;
  logic [ADDR_W-1:0] tgt_addr = '0;
  logic [1:0]        tgt_span = 2'd0;
  logic [7:0]        status_byte;
  logic              wel;
  logic              wr_permit;
  logic              chip_erase_ok;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  flash_status_guard #(.ADDR_W(ADDR_W)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_code      (cmd_code),
    .cmd_data      (cmd_data),
    .busy_in       (busy_in),
    .aai_in        (aai_in),
    .wp_n          (wp_n),
    .tgt_addr      (tgt_addr),
    .tgt_span      (tgt_span),
    .status_byte   (status_byte),
    .wel           (wel),
    .wr_permit     (wr_permit),
    .chip_erase_ok (chip_erase_ok)
  );

  // {cmd[2:0], data[7:0], wp_n, busy, expected status[7:0]}
  localparam logic [20:0] VEC [NV] = '{
    {3'd4, 8'h00, 1'b1, 1'b0, 8'h1C},  //  0 R4 unarmed write ignored
    {3'd1, 8'h00, 1'b1, 1'b0, 8'h1E},  //  1 R3 latch set
    {3'd4, 8'h00, 1'b1, 1'b0, 8'h00},  //  2 R6 accepted, latch cleared
    {3'd3, 8'h00, 1'b1, 1'b0, 8'h00},  //  3 R3 arming sets no latch
    {3'd4, 8'h0C, 1'b1, 1'b0, 8'h0C},  //  4 R4 armed by code 3
    {3'd3, 8'h00, 1'b1, 1'b0, 8'h0C},  //  5 R4 arm
    {3'd0, 8'h00, 1'b1, 1'b0, 8'h0C},  //  6 R4 intervening event
    {3'd4, 8'h00, 1'b1, 1'b0, 8'h0C},  //  7 R4 arming discarded
    {3'd1, 8'h00, 1'b1, 1'b0, 8'h0E},  //  8 R3
    {3'd4, 8'hFF, 1'b1, 1'b0, 8'h9C},  //  9 R6 level and lock together, bit5 stays 0 (R2)
    {3'd1, 8'h00, 1'b0, 1'b0, 8'h9E},  // 10 R3
    {3'd4, 8'h00, 1'b0, 1'b0, 8'h9E},  // 11 R5 pin low and locked: ignored
    {3'd1, 8'h00, 1'b1, 1'b0, 8'h9E},  // 12 R3
    {3'd4, 8'h04, 1'b1, 1'b0, 8'h04},  // 13 R5 pin high: lock cleared
    {3'd3, 8'h00, 1'b0, 1'b0, 8'h04},  // 14 R4
    {3'd4, 8'h88, 1'b0, 1'b0, 8'h88},  // 15 R5 pin low, unlocked: lock may be set
    {3'd1, 8'h00, 1'b1, 1'b1, 8'h8B},  // 16 R2 busy mirrored
    {3'd4, 8'h00, 1'b1, 1'b1, 8'h8B},  // 17 R10 refused while busy
    {3'd6, 8'h00, 1'b1, 1'b0, 8'h88},  // 18 R3 write done clears latch
    {3'd1, 8'h00, 1'b1, 1'b0, 8'h8A},  // 19 R3
    {3'd2, 8'h00, 1'b1, 1'b0, 8'h88},  // 20 R3 write disable
    {3'd1, 8'h00, 1'b1, 1'b0, 8'h8A},  // 21 R3
    {3'd5, 8'h00, 1'b1, 1'b0, 8'h8A},  // 22 R3 write start leaves latch
    {3'd6, 8'h00, 1'b1, 1'b0, 8'h88}   // 23 R3
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 3, 5, 6, 7, 14: return "R4";
      2, 4, 9:           return "R6";
      11, 13, 15:        return "R5";
      16:                return "R2";
      17:                return "R10";
      default:           return "R3";
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [2:0] c, logic [7:0] d, logic w, logic b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = c;
    cmd_data  = d;
    wp_n      = w;
    busy_in   = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_code  = 3'd0;
  endtask

  // Load a protection level with the pin high, then re-arm the latch
  task automatic set_level(logic [2:0] lvl);
    apply(3'd1, 8'h00, 1'b1, 1'b0);
    apply(3'd4, {3'b000, lvl, 2'b00}, 1'b1, 1'b0);
    apply(3'd1, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic probe(string tag, logic [ADDR_W-1:0] a, logic [1:0] s, logic exp);
    tgt_addr = a;
    tgt_span = s;
    #1;
    check(tag, {7'd0, wr_permit}, {7'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", status_byte, 8'h1C);
    check("R1 wel", {7'd0, wel}, 8'h00);
    check("R1 permit", {6'd0, wr_permit, chip_erase_ok}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][20:18], VEC[i][17:10], VEC[i][9], VEC[i][8]);
      check(vec_tag(i), status_byte, VEC[i][7:0]);
    end

    // R7 R8 level 1: upper eighth
    set_level(3'd1);
    probe("R7 lvl1 below", 19'h6FFFF, 2'd0, 1'b1);
    probe("R7 lvl1 edge", 19'h70000, 2'd0, 1'b0);
    probe("R8 block span below", 19'h65432, 2'd2, 1'b1);
    probe("R8 sector span inside", 19'h7F000, 2'd1, 1'b0);
    probe("R8 sector span below", 19'h6F800, 2'd1, 1'b1);
    // R7 level 2: upper quarter
    set_level(3'd2);
    probe("R7 lvl2 below", 19'h5FFFF, 2'd0, 1'b1);
    probe("R7 lvl2 edge", 19'h60000, 2'd0, 1'b0);
    // R7 level 3: upper half
    set_level(3'd3);
    probe("R7 lvl3 below", 19'h3FFFF, 2'd0, 1'b1);
    probe("R7 lvl3 edge", 19'h40000, 2'd0, 1'b0);
    probe("R8 span3 block below", 19'h31234, 2'd3, 1'b1);
    // R7 level 5: whole array
    set_level(3'd5);
    probe("R7 lvl5 bottom", 19'h00000, 2'd0, 1'b0);
    check("R9 chip erase at lvl5", {7'd0, chip_erase_ok}, 8'h00);
    // R7 level 0: nothing protected
    set_level(3'd0);
    probe("R7 lvl0 top", 19'h7FFFF, 2'd2, 1'b1);
    check("R9 chip erase at lvl0", {7'd0, chip_erase_ok}, 8'h01);
    apply(3'd2, 8'h00, 1'b1, 1'b0);
    probe("R8 latch clear", 19'h00000, 2'd0, 1'b0);
    check("R9 latch clear", {7'd0, chip_erase_ok}, 8'h00);
    // R2 mode flag mirror
    aai_in = 1'b1;
    #1;
    check("R2 aai bit", status_byte, 8'h40);
    aai_in = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule